// File: doc/BRIEF.md
# Latency-Tagged Pipelined Execution Unit with Slot Reservation

This block is a fixed-depth execution pipeline. Every instruction it accepts carries a payload, a total latency and an initiation interval. The instruction first waits in a single dispatch register for its initiation interval. It then joins the pipeline part way down, at stage `latency - interval`, and drains towards stage 0. From stage 0 it lands in the result register. The result appears exactly `latency + 1` clock edges after the edge that accepted the issue.

Two results must never need the same writeback cycle. To guarantee this, the unit keeps a reservation vector in which each bit stands for one future writeback slot. The issue check reads the reservation bit at the incoming latency combinationally. An accepted issue sets that bit, and the vector shifts one place towards bit 0 on every edge. A parameter `MEM_MODE` selects a variant that skips the reservation test and needs only an empty dispatch register.

The dispatch register is controlled by a two-state machine:
- `D_EMPTY` moves to `D_HOLD` on an accepted issue.
- `D_HOLD` counts down the interval and moves back to `D_EMPTY` on the edge where the countdown is zero. On that edge it inserts the instruction into the pipeline.

Top module: `occ_pipe_unit`

## Requirements
- R1: A synchronous active-high reset empties the dispatch register, the pipeline and the reservation vector. After reset `res_valid` is low and a legal issue is ready.
- R2: An issue accepted with interval `ii` keeps `iss_ready` low until `ii` more edges have passed. A new issue can be accepted no earlier than `ii + 1` edges after the previous one.
- R3: Outside `MEM_MODE`, `iss_ready` is low whenever an issue accepted on the next edge would produce its result in the same cycle as a result already in flight.
- R4: A result is due `iss_lat + 1` edges after the accepting edge. It is presented as a one-cycle `res_valid` pulse carrying the accepted `iss_data`.
- R5: An issue is illegal, and `iss_ready` is low for it, if any of these holds:
  - `iss_ii` is 0;
  - `iss_ii` is greater than `iss_lat`;
  - `iss_lat - iss_ii` is DEPTH or more;
  - `iss_lat` is MAX_LAT or more.
- R6: With `MEM_MODE` = 1, the reservation vector is ignored. `iss_ready` depends only on legality (R5) and an empty dispatch register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_data | input | PAY_W | Instruction payload |
| iss_lat | input | LAT_W | Total latency in cycles |
| iss_ii | input | LAT_W | Initiation interval in cycles |
| res_valid | output | 1 | Completed instruction present |
| res_data | output | PAY_W | Payload of the completed instruction |

## Verification
`iss_ready` is combinational, so the bench drives inputs at the falling edge and compares `iss_ready` one nanosecond later. The expected value comes from a bench model of the busy window and a table of due cycles. The bench counts rising edges. An issue accepted at edge `n` is written into a 64-entry due table at slot `n + lat + 1`, and `res_valid` and `res_data` are compared at every falling edge against the entry for the edge just taken. A second instance in `MEM_MODE` gets a directed colliding pair. There the standard unit must refuse the second issue (R3) and the variant must accept it (R6).

// File: rtl/occ_pipe_pkg.sv
package occ_pipe_pkg;
    typedef enum logic [0:0] {
        D_EMPTY = 1'b0,
        D_HOLD  = 1'b1
    } disp_state_t;
endpackage

// File: rtl/occ_pipe_occ.sv
// Writeback-slot reservation vector: set at the issued latency, then shift.
module occ_pipe_occ #(
    parameter int MAX_LAT = 512,
    parameter int LAT_W   = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [LAT_W-1:0]   probe_lat,
    output logic               hit,
    output logic [MAX_LAT-1:0] occ_q
);
    logic [MAX_LAT-1:0] onehot;

    assign onehot = MAX_LAT'(1) << probe_lat;
    assign hit    = |(occ_q & onehot);

    // Set before shift: the bit lands at lat-1, which is the value the
    // next cycle's probe must see for a colliding issue.
    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else begin
            occ_q <= (occ_q | (set_en ? onehot : '0)) >> 1;
        end
    end
endmodule

// File: rtl/occ_pipe_disp.sv
// Dispatch register with interval countdown.
module occ_pipe_disp
    import occ_pipe_pkg::*;
#(
    parameter int PAY_W = 16,
    parameter int LAT_W = 9,
    parameter int ST_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [PAY_W-1:0] in_data,
    input  logic [LAT_W-1:0] in_lat,
    input  logic [LAT_W-1:0] in_ii,
    output logic             busy,
    output logic             ins_fire,
    output logic [ST_W-1:0]  ins_stage,
    output logic [PAY_W-1:0] ins_data
);
    disp_state_t      state_q, state_d;
    logic [LAT_W-1:0] cnt_q;
    logic [PAY_W-1:0] data_q;
    logic [ST_W-1:0]  stage_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            D_EMPTY: if (accept)                state_d = D_HOLD;
            D_HOLD:  if (cnt_q == '0)           state_d = D_EMPTY;
            default:                            state_d = D_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= D_EMPTY;
            cnt_q   <= '0;
            data_q  <= '0;
            stage_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q   <= in_ii - LAT_W'(1);
                data_q  <= in_data;
                stage_q <= ST_W'(in_lat - in_ii);
            end else if (state_q == D_HOLD && cnt_q != '0) begin
                cnt_q <= cnt_q - LAT_W'(1);
            end
        end
    end

    always_comb begin
        busy      = (state_q == D_HOLD);
        ins_fire  = (state_q == D_HOLD) && (cnt_q == '0);
        ins_stage = stage_q;
        ins_data  = data_q;
    end
endmodule

// File: rtl/occ_pipe_stages.sv
// Shift pipeline draining toward stage 0, then the result register.
module occ_pipe_stages #(
    parameter int PAY_W = 16,
    parameter int DEPTH = 8,
    parameter int ST_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_fire,
    input  logic [ST_W-1:0]  ins_stage,
    input  logic [PAY_W-1:0] ins_data,
    output logic [DEPTH-1:0] stage_vld,
    output logic             res_valid,
    output logic [PAY_W-1:0] res_data
);
    logic [DEPTH-1:0] vld_q, vld_d;
    logic [PAY_W-1:0] dat_q [DEPTH];
    logic [PAY_W-1:0] dat_d [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        logic             hit;
        logic             up_v;
        logic [PAY_W-1:0] up_d;
        assign hit = ins_fire && (ins_stage == ST_W'(s));
        if (s == DEPTH - 1) begin : g_top
            assign up_v = 1'b0;
            assign up_d = '0;
        end else begin : g_mid
            assign up_v = vld_q[s+1];
            assign up_d = dat_q[s+1];
        end
        assign vld_d[s] = hit | up_v;
        assign dat_d[s] = hit ? ins_data : up_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q     <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
            for (int i = 0; i < DEPTH; i++) dat_q[i] <= '0;
        end else begin
            vld_q     <= vld_d;
            res_valid <= vld_q[0];
            res_data  <= dat_q[0];
            for (int i = 0; i < DEPTH; i++) dat_q[i] <= dat_d[i];
        end
    end

    assign stage_vld = vld_q;
endmodule

// File: rtl/occ_pipe_unit.sv
module occ_pipe_unit #(
    parameter int PAY_W    = 16,
    parameter int DEPTH    = 8,
    parameter int MAX_LAT  = 512,
    parameter bit MEM_MODE = 1'b0,
    localparam int LAT_W   = (MAX_LAT > 2) ? $clog2(MAX_LAT) : 1,
    localparam int ST_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_valid,
    output logic             iss_ready,
    input  logic [PAY_W-1:0] iss_data,
    input  logic [LAT_W-1:0] iss_lat,
    input  logic [LAT_W-1:0] iss_ii,
    output logic             res_valid,
    output logic [PAY_W-1:0] res_data
);
    logic               iss_legal;
    logic               iss_accept;
    logic               occ_hit;
    logic [MAX_LAT-1:0] occ_vec;
    logic               disp_busy;
    logic               ins_fire;
    logic [ST_W-1:0]    ins_stage;
    logic [PAY_W-1:0]   ins_data;
    logic [DEPTH-1:0]   stage_vld;

    assign iss_legal = (iss_ii != '0) && (iss_ii <= iss_lat)
                    && (32'(iss_lat - iss_ii) < DEPTH)
                    && (32'(iss_lat) < MAX_LAT);
    assign iss_ready  = iss_legal && !disp_busy && !occ_hit;
    assign iss_accept = iss_valid && iss_ready;

    if (MEM_MODE) begin : g_no_occ
        assign occ_hit = 1'b0;
        assign occ_vec = '0;
    end else begin : g_occ
        occ_pipe_occ #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) occ_i (
            .clk(clk), .rst(rst), .set_en(iss_accept), .probe_lat(iss_lat),
            .hit(occ_hit), .occ_q(occ_vec)
        );
    end

    occ_pipe_disp #(.PAY_W(PAY_W), .LAT_W(LAT_W), .ST_W(ST_W)) disp_i (
        .clk(clk), .rst(rst), .accept(iss_accept), .in_data(iss_data),
        .in_lat(iss_lat), .in_ii(iss_ii), .busy(disp_busy),
        .ins_fire(ins_fire), .ins_stage(ins_stage), .ins_data(ins_data)
    );

    occ_pipe_stages #(.PAY_W(PAY_W), .DEPTH(DEPTH), .ST_W(ST_W)) stages_i (
        .clk(clk), .rst(rst), .ins_fire(ins_fire), .ins_stage(ins_stage),
        .ins_data(ins_data), .stage_vld(stage_vld),
        .res_valid(res_valid), .res_data(res_data)
    );
endmodule

// File: rtl/occ_pipe_unit_chk.sv
module occ_pipe_unit_chk #(
    parameter int DEPTH    = 8,
    parameter int MAX_LAT  = 512,
    parameter int LAT_W    = 9,
    parameter int ST_W     = 3,
    parameter bit MEM_MODE = 1'b0
) (
    input logic               clk,
    input logic               rst,
    input logic               iss_valid,
    input logic               iss_ready,
    input logic [LAT_W-1:0]   iss_lat,
    input logic [LAT_W-1:0]   iss_ii,
    input logic               disp_busy,
    input logic               ins_fire,
    input logic [ST_W-1:0]    ins_stage,
    input logic [DEPTH-1:0]   stage_vld,
    input logic [MAX_LAT-1:0] occ_vec,
    input logic               res_valid
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && !disp_busy && stage_vld == '0));

    // R2
    accept_loads_disp_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready) |=> disp_busy);

    // R2
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        disp_busy |-> !iss_ready);

    // R5
    illegal_refused_chk: assert property (@(posedge clk) disable iff (rst)
        iss_ready |-> (iss_ii != '0 && iss_ii <= iss_lat
                       && 32'(iss_lat - iss_ii) < DEPTH));

    // R3
    slot_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (!MEM_MODE && iss_valid && iss_ready)
            |=> occ_vec[$past(iss_lat) - LAT_W'(1)]);

    // R3
    no_stage_clash_chk: assert property (@(posedge clk) disable iff (rst)
        (!MEM_MODE && ins_fire && 32'(ins_stage) != DEPTH - 1)
            |-> !stage_vld[ins_stage + ST_W'(1)]);
endmodule

bind occ_pipe_unit occ_pipe_unit_chk #(
    .DEPTH(DEPTH), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W), .ST_W(ST_W),
    .MEM_MODE(MEM_MODE)
) chk_i (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_lat(iss_lat), .iss_ii(iss_ii), .disp_busy(disp_busy),
    .ins_fire(ins_fire), .ins_stage(ins_stage), .stage_vld(stage_vld),
    .occ_vec(occ_vec), .res_valid(res_valid)
);

// File: tb/occ_pipe_unit_tb_top.sv
`timescale 1ns/1ps
module occ_pipe_unit_tb_top;
    localparam int PAY_W = 16;
    localparam int DEPTH = 8;
    localparam int LAT_W = 9;
    localparam int SZ    = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             iss_valid = 1'b0;
    logic             iss_ready;
    logic [PAY_W-1:0] iss_data = '0;
    logic [LAT_W-1:0] iss_lat = '0;
    logic [LAT_W-1:0] iss_ii = '0;
    logic             res_valid;
    logic [PAY_W-1:0] res_data;

    logic             m_valid = 1'b0;
    logic             m_ready;
    logic [PAY_W-1:0] m_data = '0;
    logic [LAT_W-1:0] m_lat = '0;
    logic [LAT_W-1:0] m_ii = '0;
    logic             m_res_valid;
    logic [PAY_W-1:0] m_res_data;

    int total = 0;
    int bad   = 0;

    logic             due_v [SZ];
    logic [PAY_W-1:0] due_d [SZ];
    int cyc        = 0;
    int busy_until = 0;

    always #4 clk = ~clk;

    occ_pipe_unit #(.PAY_W(PAY_W), .DEPTH(DEPTH), .MAX_LAT(512)) dut_i (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_data(iss_data), .iss_lat(iss_lat), .iss_ii(iss_ii),
        .res_valid(res_valid), .res_data(res_data)
    );

    occ_pipe_unit #(.PAY_W(PAY_W), .DEPTH(DEPTH), .MAX_LAT(512), .MEM_MODE(1'b1)) dut_mem_i (
        .clk(clk), .rst(rst), .iss_valid(m_valid), .iss_ready(m_ready),
        .iss_data(m_data), .iss_lat(m_lat), .iss_ii(m_ii),
        .res_valid(m_res_valid), .res_data(m_res_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic bit legal_f(input int lat, input int ii);
        return ii != 0 && ii <= lat && (lat - ii) < DEPTH && lat < 512;
    endfunction

    function automatic bit ready_f(input int lat, input int ii);
        return legal_f(lat, ii) && cyc >= busy_until && !due_v[(cyc + lat + 2) % SZ];
    endfunction

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7041));
        for (int i = 0; i < SZ; i++) begin due_v[i] = 1'b0; due_d[i] = '0; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: outputs idle, legal issue ready
        iss_lat = 9'd4; iss_ii = 9'd1; m_lat = 9'd4; m_ii = 9'd1;
        #1;
        check(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
        check(iss_ready == 1'b1, "R1 ready after reset", iss_ready, 1);
        check(m_ready == 1'b1, "R1 mem ready after reset", m_ready, 1);

        // Directed colliding pair on both units: A lat4 ii1, then B lat2 ii1
        iss_valid = 1'b1; m_valid = 1'b1; iss_data = 16'hA0A0; m_data = 16'hA0A0;
        @(posedge clk);
        @(negedge clk);
        iss_lat = 9'd2; m_lat = 9'd2; iss_data = 16'hB0B0; m_data = 16'hB0B0;
        #1;
        check(iss_ready == 1'b0, "R2 busy during interval", iss_ready, 0);
        check(m_ready == 1'b0, "R2 mem busy during interval", m_ready, 0);
        @(posedge clk);
        @(negedge clk);
        #1;
        check(iss_ready == 1'b0, "R3 colliding slot refused", iss_ready, 0);
        check(m_ready == 1'b1, "R6 mem ignores reservation", m_ready, 1);
        iss_valid = 1'b0; m_valid = 1'b0;
        repeat (20) @(posedge clk);

        // Second reset, then random phase on the standard unit
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(res_valid == 1'b0, "R1 res_valid after second reset", res_valid, 0);
        cyc = 0;
        busy_until = 0;

        for (int it = 0; it < 4000; it++) begin
            int lat, ii;
            bit v, rexp;
            logic [PAY_W-1:0] d;
            if (it != 0) @(negedge clk);
            // R4: result due table for the edge just taken
            check(res_valid == due_v[cyc % SZ], "R4 res_valid", res_valid, due_v[cyc % SZ]);
            if (due_v[cyc % SZ])
                check(res_data == due_d[cyc % SZ], "R4 res_data", res_data, due_d[cyc % SZ]);
            due_v[cyc % SZ] = 1'b0;

            ii  = 1 + int'($urandom % 4);
            lat = ii + int'($urandom % DEPTH);
            if ($urandom % 20 == 0) begin
                if ($urandom % 2 == 0) ii = 0;
                else lat = ii + DEPTH;
            end
            if (it < 8) begin
                // R5 directed: illegal encodings first
                case (it % 4)
                    0: begin ii = 0; lat = 3; end
                    1: begin ii = 5; lat = 4; end
                    2: begin ii = 1; lat = 1 + DEPTH; end
                    default: begin ii = 2; lat = 2 + DEPTH - 1; end
                endcase
            end
            v = ($urandom % 10) < 7;
            d = PAY_W'($urandom);
            iss_valid = v; iss_lat = LAT_W'(lat); iss_ii = LAT_W'(ii); iss_data = d;
            #1;
            rexp = ready_f(lat, ii);
            if (!legal_f(lat, ii))
                check(iss_ready == rexp, "R5 illegal refused", iss_ready, rexp);
            else if (cyc < busy_until)
                check(iss_ready == rexp, "R2 busy window", iss_ready, rexp);
            else
                check(iss_ready == rexp, "R3 reservation check", iss_ready, rexp);
            if (v && rexp) begin
                due_v[(cyc + lat + 2) % SZ] = 1'b1;
                due_d[(cyc + lat + 2) % SZ] = d;
                busy_until = cyc + 1 + ii;
            end
            @(posedge clk);
            cyc++;
        end
        iss_valid = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule